// File: doc/BRIEF.md
# Banked GPIO Controller with Selectable-Edge Interrupts

The block is a register-mapped general-purpose I/O controller with three pin banks. Bank one is a small input-only group that reports synchronised pad levels. Banks two (three pins) and three (twelve pins) are configurable. Each of their pins has a direction bit, an output latch, an edge-select bit and an interrupt-enable bit. Each configurable bank also owns one extra output pin. That pin has its own register and no configuration or interrupt.

Every pad input passes through a two-flop synchroniser. An edge detector then compares each pin's level with its value one cycle earlier. When the selected edge appears on an enabled pin, the block raises a one-cycle pulse on that pin's dedicated interrupt output. An interrupt controller downstream collects these pulses. Register reads are combinational from the address. A write takes effect on the clock edge where `wr_i` is high.

Top module: `gpio_banks`

## Requirements
- R1: After reset every register reads 0, every output enable, output value and extra pin is 0, and no interrupt output is high.
- R2: Offset 0x00 reads the bank-one pad levels in bits [1:0], delayed by two clock edges. Writes to 0x00 change nothing.
- R3: A direction bit of 1 makes the pin an output, and the pin's `*_oe_o` bit follows it from the edge of the write. Bank two's direction lives at 0x11 bits [2:0] and bank three's at 0x22 bits [11:0].
- R4: A write to a data register loads the output latch, which drives `*_out_o`. A data read returns the latch bit for output pins and the synchronised pad bit for input pins.
- R5: An edge-select bit of 1 picks rising edges. An enabled pin whose level goes 0 to 1 gives a high interrupt for exactly one cycle.
- R6: An edge-select bit of 0 picks falling edges. An enabled pin whose level goes 1 to 0 gives a high interrupt for exactly one cycle.
- R7: An enable bit of 0 keeps that pin's interrupt low whatever its level does.
- R8: The extra pins are always driven. Bank two's comes from bit 0 of 0x14 and bank three's from bit 0 of 0x28. They never raise an interrupt, and direction, edge-select and enable writes leave them unchanged.
- R9: Bank two's registers are at 0x10 (data), 0x11 (direction), 0x12 (edge select) and 0x13 (enable). Bank three's are at 0x20, 0x22, 0x24 and 0x26. Bits above a bank's width read 0. Unmapped offsets read 0, and writes to them change nothing.
- R10: The edge detector of an output pin watches the driven latch value, so a latch write that forms the selected edge on an enabled output pin raises its interrupt.
- R11: A pad change applied before clock edge k shows in the data readback after edge k+1. It raises its interrupt between edges k+1 and k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| b1_pad_i | input | 2 | Bank one pads |
| b2_pad_i | input | 3 | Bank two pads |
| b3_pad_i | input | 12 | Bank three pads |
| b2_out_o | output | 3 | Bank two output values |
| b2_oe_o | output | 3 | Bank two output enables |
| b3_out_o | output | 12 | Bank three output values |
| b3_oe_o | output | 12 | Bank three output enables |
| b2_irq_o | output | 3 | Bank two interrupt pulses |
| b3_irq_o | output | 12 | Bank three interrupt pulses |
| x2_o | output | 1 | Bank two extra pin |
| x3_o | output | 1 | Bank three extra pin |

## Verification
Directed sequences test one pad at a time for rising and falling edges, with the pin enabled and then disabled. These separate the edge polarity from the gating, and they show the two-edge latency as the exact cycle the pulse appears. A latch write on an enabled output pin checks that the detector follows the driven value and not the pad. Random phases then mix register writes at mapped and unmapped offsets with pads that toggle freely across both banks. A cycle-accurate bench model catches decode slips, a wrong bit width and misrouted readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  parameter int ADDR_W = 6;
  parameter int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFF_B1_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_B2_DATA = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_B2_DIR  = 6'h11;
  localparam logic [ADDR_W-1:0] OFF_B2_EDGE = 6'h12;
  localparam logic [ADDR_W-1:0] OFF_B2_EN   = 6'h13;
  localparam logic [ADDR_W-1:0] OFF_B2_X    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_B3_DATA = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_B3_DIR  = 6'h22;
  localparam logic [ADDR_W-1:0] OFF_B3_EDGE = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_B3_EN   = 6'h26;
  localparam logic [ADDR_W-1:0] OFF_B3_X    = 6'h28;

  typedef struct packed {
    logic data;
    logic dir;
    logic edge_sel;
    logic en;
  } bank_we_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  input  bank_we_t     we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] irq_o
);
  logic [W-1:0] sync, lvl, prev_q;
  logic [W-1:0] out_q, dir_q, edge_q, en_q;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      en_q   <= '0;
    end else begin
      if (we_i.data)     out_q  <= wdata_i;
      if (we_i.dir)      dir_q  <= wdata_i;
      if (we_i.edge_sel) edge_q <= wdata_i;
      if (we_i.en)       en_q   <= wdata_i;
    end
  end

  // output pins observe their own driven value
  assign lvl = (dir_q & out_q) | (~dir_q & sync);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end

  assign irq_o  = en_q & ((edge_q & lvl & ~prev_q) | (~edge_q & ~lvl & prev_q));
  assign data_o = lvl;
  assign dir_o  = dir_q;
  assign edge_o = edge_q;
  assign en_o   = en_q;
  assign out_o  = out_q;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i.dir |=> dir_q == $past(wdata_i)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i.data |=> $stable(out_q)); // R4

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] && edge_q[i] |-> lvl[i] && !$past(lvl[i])); // R5
    AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] && !edge_q[i] |-> !lvl[i] && $past(lvl[i])); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |=> !irq_o[i] || (edge_q[i] != $past(edge_q[i]))); // R11
  end
endmodule

// File: rtl/gpio_banks.sv
module gpio_banks
  import gpio_pkg::*;
#(
  parameter int B1_W = 2,
  parameter int B2_W = 3,
  parameter int B3_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [B1_W-1:0]   b1_pad_i,
  input  logic [B2_W-1:0]   b2_pad_i,
  input  logic [B3_W-1:0]   b3_pad_i,
  output logic [B2_W-1:0]   b2_out_o,
  output logic [B2_W-1:0]   b2_oe_o,
  output logic [B3_W-1:0]   b3_out_o,
  output logic [B3_W-1:0]   b3_oe_o,
  output logic [B2_W-1:0]   b2_irq_o,
  output logic [B3_W-1:0]   b3_irq_o,
  output logic              x2_o,
  output logic              x3_o
);
  localparam int B3_PAD = DATA_W - B3_W;

  logic [B1_W-1:0] b1_sync;
  logic [B2_W-1:0] b2_data, b2_dir, b2_edge, b2_en;
  logic [B3_W-1:0] b3_data, b3_dir, b3_edge, b3_en;
  bank_we_t        we2, we3;
  logic            x2_q, x3_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:B3_W];

  always_comb begin
    we2.data     = wr_i && addr_i == OFF_B2_DATA;
    we2.dir      = wr_i && addr_i == OFF_B2_DIR;
    we2.edge_sel = wr_i && addr_i == OFF_B2_EDGE;
    we2.en       = wr_i && addr_i == OFF_B2_EN;
    we3.data     = wr_i && addr_i == OFF_B3_DATA;
    we3.dir      = wr_i && addr_i == OFF_B3_DIR;
    we3.edge_sel = wr_i && addr_i == OFF_B3_EDGE;
    we3.en       = wr_i && addr_i == OFF_B3_EN;
  end

  gpio_sync #(.W(B1_W)) u_b1_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (b1_pad_i),
    .q_o   (b1_sync)
  );

  gpio_bank #(.W(B2_W)) u_bank2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (b2_pad_i),
    .we_i   (we2),
    .wdata_i(wdata_i[B2_W-1:0]),
    .data_o (b2_data),
    .dir_o  (b2_dir),
    .edge_o (b2_edge),
    .en_o   (b2_en),
    .out_o  (b2_out_o),
    .irq_o  (b2_irq_o)
  );

  gpio_bank #(.W(B3_W)) u_bank3 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (b3_pad_i),
    .we_i   (we3),
    .wdata_i(wdata_i[B3_W-1:0]),
    .data_o (b3_data),
    .dir_o  (b3_dir),
    .edge_o (b3_edge),
    .en_o   (b3_en),
    .out_o  (b3_out_o),
    .irq_o  (b3_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x2_q <= 1'b0;
      x3_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == OFF_B2_X) x2_q <= wdata_i[0];
      if (wr_i && addr_i == OFF_B3_X) x3_q <= wdata_i[0];
    end
  end

  assign b2_oe_o = b2_dir;
  assign b3_oe_o = b3_dir;
  assign x2_o    = x2_q;
  assign x3_o    = x3_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_B1_DATA: rdata_o[B1_W-1:0] = b1_sync;
      OFF_B2_DATA: rdata_o[B2_W-1:0] = b2_data;
      OFF_B2_DIR:  rdata_o[B2_W-1:0] = b2_dir;
      OFF_B2_EDGE: rdata_o[B2_W-1:0] = b2_edge;
      OFF_B2_EN:   rdata_o[B2_W-1:0] = b2_en;
      OFF_B2_X:    rdata_o[0]        = x2_q;
      OFF_B3_DATA: rdata_o = {{B3_PAD{1'b0}}, b3_data};
      OFF_B3_DIR:  rdata_o = {{B3_PAD{1'b0}}, b3_dir};
      OFF_B3_EDGE: rdata_o = {{B3_PAD{1'b0}}, b3_edge};
      OFF_B3_EN:   rdata_o = {{B3_PAD{1'b0}}, b3_en};
      OFF_B3_X:    rdata_o[0]        = x3_q;
      default:     rdata_o = '0;
    endcase
  end

  AST_X_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFF_B2_X) |=> $stable(x2_q)); // R8
endmodule

// File: tb/test_gpio_banks.sv
module test_gpio_banks;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  p1 = '0;
  logic [2:0]  p2 = '0;
  logic [11:0] p3 = '0;
  logic [2:0]  b2_out, b2_oe, b2_irq;
  logic [11:0] b3_out, b3_oe, b3_irq;
  logic        x2, x3;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [1:0]  h1a = '0, h1b = '0;
  logic [2:0]  d2 = '0, c2 = '0, e2 = '0, o2 = '0, h2a = '0, h2b = '0, pv2 = '0;
  logic [11:0] d3 = '0, c3 = '0, e3 = '0, o3 = '0, h3a = '0, h3b = '0, pv3 = '0;
  logic        xm2 = 1'b0, xm3 = 1'b0;

  always #5 clk = ~clk;

  gpio_banks i_gpio_banks (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .b1_pad_i(p1), .b2_pad_i(p2), .b3_pad_i(p3),
    .b2_out_o(b2_out), .b2_oe_o(b2_oe), .b3_out_o(b3_out), .b3_oe_o(b3_oe),
    .b2_irq_o(b2_irq), .b3_irq_o(b3_irq), .x2_o(x2), .x3_o(x3)
  );

  function automatic logic [2:0] lvl2();
    return (d2 & o2) | (~d2 & h2b);
  endfunction
  function automatic logic [11:0] lvl3();
    return (d3 & o3) | (~d3 & h3b);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00: return {14'b0, h1b};
      6'h10: return {13'b0, lvl2()};
      6'h11: return {13'b0, d2};
      6'h12: return {13'b0, c2};
      6'h13: return {13'b0, e2};
      6'h14: return {15'b0, xm2};
      6'h20: return {4'b0, lvl3()};
      6'h22: return {4'b0, d3};
      6'h24: return {4'b0, c3};
      6'h26: return {4'b0, e3};
      6'h28: return {15'b0, xm3};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [2:0] exp_irq2();
    logic [2:0] l = lvl2();
    return e2 & ((c2 & l & ~pv2) | (~c2 & ~l & pv2));
  endfunction
  function automatic logic [11:0] exp_irq3();
    logic [11:0] l = lvl3();
    return e3 & ((c3 & l & ~pv3) | (~c3 & ~l & pv3));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input string tag, input logic w, input logic [5:0] a, input logic [15:0] d);
    logic [2:0]  l2;
    logic [11:0] l3;
    wr = w; addr = a; wdata = d;
    @(posedge clk);
    l2 = lvl2(); l3 = lvl3();
    pv2 = l2; pv3 = l3;
    h1b = h1a; h1a = p1;
    h2b = h2a; h2a = p2;
    h3b = h3a; h3a = p3;
    if (w) begin
      case (a)
        6'h10: o2 = d[2:0];
        6'h11: d2 = d[2:0];
        6'h12: c2 = d[2:0];
        6'h13: e2 = d[2:0];
        6'h14: xm2 = d[0];
        6'h20: o3 = d[11:0];
        6'h22: d3 = d[11:0];
        6'h24: c3 = d[11:0];
        6'h26: e3 = d[11:0];
        6'h28: xm3 = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk({tag, " rdata"}, {16'h0, rdata}, {16'h0, exp_rd(a)});
    chk({tag, " irq2"}, {29'h0, b2_irq}, {29'h0, exp_irq2()});
    chk({tag, " irq3"}, {20'h0, b3_irq}, {20'h0, exp_irq3()});
    chk({tag, " pins2"}, {24'h0, b2_oe, b2_out, x2}, {24'h0, d2, o2, xm2});
    chk({tag, " pins3"}, {6'h0, b3_oe, b3_out, x3}, {6'h0, d3, o3, xm3});
  endtask

  function automatic logic [5:0] pick_addr(input int k);
    case (k % 13)
      0: return 6'h00;  1: return 6'h10;  2: return 6'h11;  3: return 6'h12;
      4: return 6'h13;  5: return 6'h14;  6: return 6'h20;  7: return 6'h22;
      8: return 6'h24;  9: return 6'h26;  10: return 6'h28; 11: return 6'h30;
      default: return 6'h15;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state on every offset
    for (int k = 0; k < 13; k++) cyc("R1", 1'b0, pick_addr(k), 16'h0);

    // R2 bank one levels, write ignored
    p1 = 2'b10;
    cyc("R2", 1'b0, 6'h00, 16'h0);
    cyc("R2", 1'b0, 6'h00, 16'h0);
    cyc("R2", 1'b1, 6'h00, 16'hffff);
    cyc("R2", 1'b0, 6'h00, 16'h0);

    // R3 direction and output enables
    cyc("R3", 1'b1, 6'h11, 16'hfffd);
    cyc("R3", 1'b0, 6'h11, 16'h0);
    cyc("R3", 1'b1, 6'h22, 16'hfa5c);
    cyc("R3", 1'b0, 6'h22, 16'h0);

    // R4 data readback mixes latch and pad
    p2 = 3'b010;
    cyc("R4", 1'b1, 6'h10, 16'h0007);
    cyc("R4", 1'b0, 6'h10, 16'h0);
    cyc("R4", 1'b0, 6'h10, 16'h0);
    p2 = 3'b000;
    cyc("R4", 1'b0, 6'h10, 16'h0);
    cyc("R4", 1'b0, 6'h10, 16'h0);

    // R5 R11 rising edge on input pin 1
    cyc("R5", 1'b1, 6'h12, 16'h0002);
    cyc("R5", 1'b1, 6'h13, 16'h0002);
    p2 = 3'b010;
    for (int k = 0; k < 4; k++) cyc("R5 R11", 1'b0, 6'h10, 16'h0);

    // R6 falling edge
    cyc("R6", 1'b1, 6'h12, 16'h0000);
    p2 = 3'b000;
    for (int k = 0; k < 4; k++) cyc("R6 R11", 1'b0, 6'h10, 16'h0);

    // R7 disabled pin gives nothing
    cyc("R7", 1'b1, 6'h13, 16'h0000);
    p2 = 3'b010;
    for (int k = 0; k < 3; k++) cyc("R7", 1'b0, 6'h13, 16'h0);
    p2 = 3'b000;
    for (int k = 0; k < 3; k++) cyc("R7", 1'b0, 6'h13, 16'h0);

    // R10 output pin 0 edge from driven latch
    cyc("R10", 1'b1, 6'h12, 16'h0001);
    cyc("R10", 1'b1, 6'h13, 16'h0001);
    cyc("R10", 1'b1, 6'h10, 16'h0000);
    cyc("R10", 1'b1, 6'h10, 16'h0001);
    cyc("R10", 1'b0, 6'h10, 16'h0);

    // R8 extra pins, unaffected by config writes
    cyc("R8", 1'b1, 6'h14, 16'h0001);
    cyc("R8", 1'b1, 6'h28, 16'hffff);
    cyc("R8", 1'b1, 6'h11, 16'h0000);
    cyc("R8", 1'b1, 6'h26, 16'hffff);
    cyc("R8", 1'b0, 6'h14, 16'h0);
    cyc("R8", 1'b0, 6'h28, 16'h0);

    // R9 unmapped offsets
    cyc("R9", 1'b1, 6'h30, 16'hffff);
    cyc("R9", 1'b0, 6'h30, 16'h0);
    cyc("R9", 1'b1, 6'h15, 16'hffff);
    cyc("R9", 1'b0, 6'h27, 16'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) p1 = 2'($urandom);
      if ($urandom_range(2) == 0) p2 = 3'($urandom);
      if ($urandom_range(2) == 0) p3 = 12'($urandom);
      cyc("R4 R5 R6 R7 R8 R9 R10", $urandom_range(2) == 0,
          pick_addr(int'($urandom_range(12))), 16'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule